// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block takes over the processor's control state in the cycle an exception or an external interrupt has to be serviced. Each cycle it looks at a pending exception code, a hard-interrupt request with the vector that the interrupt controller offers for the current priority mask (or a flag saying that no source qualifies), and the live status word, program counter, stack pointer, vector base and delay-slot flags. When it decides to enter a handler, it captures the saved copies of the status word, return address and stack pointer, raises privilege, blocks further events, selects the handler address for the event's class and records the cause code. All of this happens on one clock edge.

The registered outputs are the values the core loads into its architectural registers. A `taken` strobe marks the cycle in which they were refreshed. Exceptions always win over interrupts. A blocked status word turns nearly every exception into a reset-class entry and holds off interrupts unless the core has just woken from sleep. An entry from a delay slot rewinds the return address so the branch runs again. The trap instruction gets its own forward correction.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception is pending, it is serviced and any simultaneous interrupt request is ignored. The interrupt cause register keeps its value and the exception cause register receives the code.
- R2: With the block bit (status bit 28) set, a pending exception with any code except 0x1E0 is recorded and handled as code 0x000. Code 0x1E0 passes through unchanged.
- R3: With the block bit set and the wake input low, an interrupt request (with no exception pending) causes no entry. All outputs hold their values.
- R4: The wake-clear strobe pulses one cycle after a cycle in which the block bit is set and either an exception is pending, or an interrupt is pending with the wake input high. This happens even if no vector is offered.
- R5: An interrupt request with the no-vector flag set causes no entry, and all outputs hold.
- R6: On every entry, the saved status receives the status input and the saved stack pointer receives R15. The new status word is the input with bits 28 (block), 29 (bank) and 30 (privileged) set.
- R7: If flag bit 0 (unconditional delay slot) or flag bit 1 (conditional delay slot) is set on entry, the saved PC is the PC minus 2 and all three flag bits are cleared. Otherwise the saved PC is the PC and the flags pass through.
- R8: Codes 0x000, 0x020 and 0x140 clear status bit 15 (FPU disable), set status bits 7:4 (interrupt mask) to 0xF, and load PC with 0xA0000000.
- R9: Codes 0x040 and 0x060 load PC with the vector base plus 0x400.
- R10: Code 0x160 loads PC with the vector base plus 0x100 and adds 2 to the saved PC, after any delay-slot rewind.
- R11: Every other exception code loads PC with the vector base plus 0x100.
- R12: An accepted interrupt writes its vector to the interrupt cause register and loads PC with the vector base plus 0x600. The exception cause register is left unchanged.
- R13: Reset clears every output to zero. `taken` is high for exactly the one cycle after each entry. In a cycle with nothing pending, every output register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| exc_valid_i | input | 1 | An exception code is pending |
| exc_code_i | input | 12 | Pending exception code |
| irq_req_i | input | 1 | Hard-interrupt request |
| irq_none_i | input | 1 | Controller offers no vector for the current mask |
| irq_vec_i | input | 12 | Vector offered by the interrupt controller |
| wake_i | input | 1 | Core has just left sleep state |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| r15_i | input | 32 | Current stack pointer |
| vbr_i | input | 32 | Vector base |
| flags_i | input | 3 | Delay-slot flags (bit 0 unconditional, bit 1 conditional, bit 2 branch taken) |
| taken_o | output | 1 | Outputs were refreshed by an entry |
| wake_clr_o | output | 1 | Core must clear its wake flag |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved return address |
| sgr_o | output | 32 | Saved stack pointer |
| sr_o | output | 32 | New status word |
| pc_o | output | 32 | Handler address |
| expevt_o | output | 12 | Exception cause |
| intevt_o | output | 12 | Interrupt cause |
| flags_o | output | 3 | Delay-slot flags after entry |

## Verification
Several rules are checked by the assertions on every cycle, each linking the inputs of one cycle to the registered outputs of the next. These are exception priority, the blocked-state rewrite to the reset code, the holding-off of interrupts, the wake-clear pulse, the effect of the no-vector flag, the save of status and stack pointer, the interrupt handler address, and holding when idle. The class-dependent handler addresses, the delay-slot rewind combined with the trap correction, and the flag clearing are shown by the bench's directed scenarios. These scenarios are compared against a model written from the requirements.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   localparam int SR_FD_BIT  = 15;
   localparam int SR_IM_LO   = 4;
   localparam int SR_IM_W    = 4;
   localparam int SR_BL_BIT  = 28;
   localparam int SR_RB_BIT  = 29;
   localparam int SR_MD_BIT  = 30;

   typedef enum logic [1:0] {
      CLS_RESET   = 2'd0,
      CLS_TLB     = 2'd1,
      CLS_TRAP    = 2'd2,
      CLS_GENERAL = 2'd3
   } exc_class_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
   parameter int                 CODE_W    = 12,
   parameter logic [CODE_W-1:0]  PASS_CODE = 12'h1E0
) (
   input  logic              exc_valid,
   input  logic [CODE_W-1:0] exc_code,
   input  logic              irq_req,
   input  logic              irq_none,
   input  logic              blocked,
   input  logic              wake,
   output logic              take_exc,
   output logic              take_irq,
   output logic [CODE_W-1:0] eff_code,
   output logic              wake_clr
);
   logic irq_cand;

   // an interrupt is only a candidate when no exception is pending
   assign irq_cand = irq_req & ~exc_valid;
   assign take_exc = exc_valid;
   assign take_irq = irq_cand & (~blocked | wake) & ~irq_none;
   // while blocked, every code except the pass code degrades to reset
   assign eff_code = (blocked && (exc_code != PASS_CODE)) ? '0 : exc_code;
   assign wake_clr = blocked & (exc_valid | (irq_cand & wake));
endmodule

// File: rtl/exc_classify.sv
module exc_classify
   import exc_entry_pkg::*;
#(
   parameter int                         CODE_W    = 12,
   parameter int                         NUM_RST   = 3,
   parameter logic [NUM_RST*CODE_W-1:0]  RST_CODES = {12'h140, 12'h020, 12'h000},
   parameter logic [CODE_W-1:0]          TLB_CODE_A = 12'h040,
   parameter logic [CODE_W-1:0]          TLB_CODE_B = 12'h060,
   parameter logic [CODE_W-1:0]          TRAP_CODE  = 12'h160
) (
   input  logic [CODE_W-1:0] code,
   output exc_class_e        cls
);
   logic [NUM_RST-1:0] rst_hit;

   for (genvar g = 0; g < NUM_RST; g++) begin : g_rst_cmp
      assign rst_hit[g] = (code == RST_CODES[g*CODE_W +: CODE_W]);
   end

   always_comb begin
      if (|rst_hit)                                  cls = CLS_RESET;
      else if (code == TLB_CODE_A || code == TLB_CODE_B) cls = CLS_TLB;
      else if (code == TRAP_CODE)                    cls = CLS_TRAP;
      else                                           cls = CLS_GENERAL;
   end
endmodule

// File: rtl/exc_target.sv
module exc_target
   import exc_entry_pkg::*;
#(
   parameter int               XLEN       = 32,
   parameter int               FLAG_W     = 3,
   parameter logic [FLAG_W-1:0] SLOT_MASK = 3'b011,
   parameter logic [FLAG_W-1:0] CLR_MASK  = 3'b111,
   parameter int unsigned      INSN_BYTES = 2,
   parameter int unsigned      OFS_GEN    = 32'h100,
   parameter int unsigned      OFS_TLB    = 32'h400,
   parameter int unsigned      OFS_IRQ    = 32'h600,
   parameter logic [XLEN-1:0]  RESET_PC   = 32'hA000_0000
) (
   input  logic              take_exc,
   input  logic              take_irq,
   input  exc_class_e        cls,
   input  logic [XLEN-1:0]   sr,
   input  logic [XLEN-1:0]   pc,
   input  logic [XLEN-1:0]   vbr,
   input  logic [FLAG_W-1:0] flags,
   output logic [XLEN-1:0]   sr_n,
   output logic [XLEN-1:0]   pc_n,
   output logic [XLEN-1:0]   spc_n,
   output logic [FLAG_W-1:0] flags_n
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   logic in_slot;
   logic is_trap;

   assign in_slot = |(flags & SLOT_MASK);
   assign is_trap = take_exc && (cls == CLS_TRAP);

   always_comb begin
      spc_n = pc;
      if (in_slot) spc_n = spc_n - STEP;
      if (is_trap) spc_n = spc_n + STEP;
   end

   assign flags_n = in_slot ? (flags & ~CLR_MASK) : flags;

   always_comb begin
      sr_n = sr;
      sr_n[SR_BL_BIT] = 1'b1;
      sr_n[SR_MD_BIT] = 1'b1;
      sr_n[SR_RB_BIT] = 1'b1;
      if (take_exc && cls == CLS_RESET) begin
         sr_n[SR_FD_BIT] = 1'b0;
         sr_n[SR_IM_LO +: SR_IM_W] = '1;
      end
   end

   always_comb begin
      if (take_irq)              pc_n = vbr + XLEN'(OFS_IRQ);
      else if (cls == CLS_RESET) pc_n = RESET_PC;
      else if (cls == CLS_TLB)   pc_n = vbr + XLEN'(OFS_TLB);
      else                       pc_n = vbr + XLEN'(OFS_GEN);
   end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int               XLEN       = 32,
   parameter int               CODE_W     = 12,
   parameter int               FLAG_W     = 3,
   parameter logic [FLAG_W-1:0] SLOT_MASK = 3'b011,
   parameter logic [FLAG_W-1:0] CLR_MASK  = 3'b111,
   parameter logic [CODE_W-1:0] PASS_CODE = 12'h1E0,
   parameter int unsigned      OFS_IRQ    = 32'h600,
   parameter logic [XLEN-1:0]  RESET_PC   = 32'hA000_0000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              exc_valid_i,
   input  logic [CODE_W-1:0] exc_code_i,
   input  logic              irq_req_i,
   input  logic              irq_none_i,
   input  logic [CODE_W-1:0] irq_vec_i,
   input  logic              wake_i,
   input  logic [XLEN-1:0]   sr_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   r15_i,
   input  logic [XLEN-1:0]   vbr_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic              taken_o,
   output logic              wake_clr_o,
   output logic [XLEN-1:0]   ssr_o,
   output logic [XLEN-1:0]   spc_o,
   output logic [XLEN-1:0]   sgr_o,
   output logic [XLEN-1:0]   sr_o,
   output logic [XLEN-1:0]   pc_o,
   output logic [CODE_W-1:0] expevt_o,
   output logic [CODE_W-1:0] intevt_o,
   output logic [FLAG_W-1:0] flags_o
);
   if (XLEN < 32) begin : g_bad_xlen
      $error("exc_entry_seq: XLEN must hold the status bits up to 30");
   end
   if (CODE_W < 9) begin : g_bad_code
      $error("exc_entry_seq: CODE_W too narrow for the cause codes");
   end
   if (FLAG_W < 2) begin : g_bad_flag
      $error("exc_entry_seq: FLAG_W must cover both delay-slot kinds");
   end

   logic              take_exc, take_irq, wclr;
   logic [CODE_W-1:0] eff_code;
   exc_class_e        cls;
   logic [XLEN-1:0]   sr_n, pc_n, spc_n;
   logic [FLAG_W-1:0] flags_n;
   logic              take_any;

   exc_arbiter #(.CODE_W(CODE_W), .PASS_CODE(PASS_CODE)) u_arb (
      .exc_valid (exc_valid_i),
      .exc_code  (exc_code_i),
      .irq_req   (irq_req_i),
      .irq_none  (irq_none_i),
      .blocked   (sr_i[SR_BL_BIT]),
      .wake      (wake_i),
      .take_exc  (take_exc),
      .take_irq  (take_irq),
      .eff_code  (eff_code),
      .wake_clr  (wclr)
   );

   exc_classify #(.CODE_W(CODE_W)) u_cls (
      .code (eff_code),
      .cls  (cls)
   );

   exc_target #(
      .XLEN(XLEN), .FLAG_W(FLAG_W), .SLOT_MASK(SLOT_MASK), .CLR_MASK(CLR_MASK),
      .OFS_IRQ(OFS_IRQ), .RESET_PC(RESET_PC)
   ) u_tgt (
      .take_exc (take_exc),
      .take_irq (take_irq),
      .cls      (cls),
      .sr       (sr_i),
      .pc       (pc_i),
      .vbr      (vbr_i),
      .flags    (flags_i),
      .sr_n     (sr_n),
      .pc_n     (pc_n),
      .spc_n    (spc_n),
      .flags_n  (flags_n)
   );

   assign take_any = take_exc | take_irq;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         taken_o    <= 1'b0;
         wake_clr_o <= 1'b0;
         ssr_o      <= '0;
         spc_o      <= '0;
         sgr_o      <= '0;
         sr_o       <= '0;
         pc_o       <= '0;
         expevt_o   <= '0;
         intevt_o   <= '0;
         flags_o    <= '0;
      end else begin
         taken_o    <= take_any;
         wake_clr_o <= wclr;
         if (take_any) begin
            ssr_o   <= sr_i;
            spc_o   <= spc_n;
            sgr_o   <= r15_i;
            sr_o    <= sr_n;
            pc_o    <= pc_n;
            flags_o <= flags_n;
         end
         if (take_exc) expevt_o <= eff_code;
         if (take_irq) intevt_o <= irq_vec_i;
      end
   end

   assert_exc_wins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exc_valid_i |=> taken_o && $stable(intevt_o));

   assert_blocked_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exc_valid_i && sr_i[SR_BL_BIT] && exc_code_i != PASS_CODE)
      |=> (expevt_o == '0) && (pc_o == RESET_PC));

   assert_irq_held_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_req_i && !exc_valid_i && sr_i[SR_BL_BIT] && !wake_i)
      |=> !taken_o && $stable(pc_o) && $stable(intevt_o));

   assert_wake_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sr_i[SR_BL_BIT] && exc_valid_i) |=> wake_clr_o);

   assert_no_vector_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_req_i && !exc_valid_i && irq_none_i) |=> !taken_o && $stable(sr_o));

   assert_state_saved_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exc_valid_i |=> (ssr_o == $past(sr_i)) && (sgr_o == $past(r15_i))
                      && sr_o[SR_BL_BIT] && sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT]);

   assert_irq_entry_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_req_i && !exc_valid_i && !irq_none_i && !sr_i[SR_BL_BIT])
      |=> taken_o && (intevt_o == $past(irq_vec_i))
          && (pc_o == $past(vbr_i) + XLEN'(OFS_IRQ)) && $stable(expevt_o));

   assert_idle_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!exc_valid_i && !irq_req_i)
      |=> !taken_o && $stable(pc_o) && $stable(sr_o) && $stable(spc_o) && $stable(ssr_o));
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        taken;
      logic        wclr;
      logic [31:0] ssr;
      logic [31:0] spc;
      logic [31:0] sgr;
      logic [31:0] sr;
      logic [31:0] pc;
      logic [11:0] expevt;
      logic [11:0] intevt;
      logic [2:0]  flags;
   } outs_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_valid = 1'b0;
   logic [11:0] exc_code = '0;
   logic        irq_req = 1'b0;
   logic        irq_none = 1'b0;
   logic [11:0] irq_vec = '0;
   logic        wake = 1'b0;
   logic [31:0] sr = '0, pc = '0, r15 = '0, vbr = '0;
   logic [2:0]  flags = '0;
   outs_t       act;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   outs_t model;
   outs_t exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_entry_seq u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .exc_valid_i(exc_valid), .exc_code_i(exc_code),
      .irq_req_i(irq_req), .irq_none_i(irq_none), .irq_vec_i(irq_vec),
      .wake_i(wake), .sr_i(sr), .pc_i(pc), .r15_i(r15), .vbr_i(vbr), .flags_i(flags),
      .taken_o(act.taken), .wake_clr_o(act.wclr), .ssr_o(act.ssr), .spc_o(act.spc),
      .sgr_o(act.sgr), .sr_o(act.sr), .pc_o(act.pc), .expevt_o(act.expevt),
      .intevt_o(act.intevt), .flags_o(act.flags)
   );

   task automatic check(input string tag, input outs_t got, input outs_t want);
      tests++;
      if (got !== want) begin
         fails++;
         $display("FAIL %s: actual taken=%0b wclr=%0b ssr=%h spc=%h sgr=%h sr=%h pc=%h exp=%h int=%h fl=%b expected taken=%0b wclr=%0b ssr=%h spc=%h sgr=%h sr=%h pc=%h exp=%h int=%h fl=%b",
                  tag, got.taken, got.wclr, got.ssr, got.spc, got.sgr, got.sr, got.pc,
                  got.expevt, got.intevt, got.flags, want.taken, want.wclr, want.ssr,
                  want.spc, want.sgr, want.sr, want.pc, want.expevt, want.intevt, want.flags);
      end
   endtask

   // driver: applies one cycle of stimulus and predicts the outputs after the edge
   task automatic drive(input string tag, input bit ev, input logic [11:0] code,
                        input bit irq, input bit none, input logic [11:0] vec,
                        input bit wk, input logic [31:0] s, input logic [31:0] p,
                        input logic [2:0] fl);
      bit bl, t_exc, t_irq, slot;
      logic [11:0] c;
      @(negedge clk);
      exc_valid = ev; exc_code = code; irq_req = irq; irq_none = none; irq_vec = vec;
      wake = wk; sr = s; pc = p; r15 = p ^ 32'h5A5A_0F0F; vbr = 32'h8C00_0000; flags = fl;
      bl    = s[28];
      t_exc = ev;
      t_irq = irq && !ev && (!bl || wk) && !none;
      c     = (bl && code != 12'h1E0) ? 12'h000 : code;
      slot  = fl[0] | fl[1];
      model.taken = t_exc | t_irq;
      model.wclr  = bl && (ev || (irq && wk));
      if (t_exc || t_irq) begin
         model.ssr   = s;
         model.sgr   = r15;
         model.spc   = slot ? p - 32'd2 : p;
         model.flags = slot ? 3'b000 : fl;
         model.sr    = s | 32'h7000_0000;
         if (t_irq) begin
            model.intevt = vec;
            model.pc     = vbr + 32'h600;
         end else begin
            model.expevt = c;
            if (c == 12'h000 || c == 12'h020 || c == 12'h140) begin
               model.sr[15]  = 1'b0;
               model.sr[7:4] = 4'hF;
               model.pc      = 32'hA000_0000;
            end else if (c == 12'h040 || c == 12'h060) begin
               model.pc = vbr + 32'h400;
            end else begin
               if (c == 12'h160) model.spc = model.spc + 32'd2;
               model.pc = vbr + 32'h100;
            end
         end
      end
      exp_q.push_back(model);
      tag_q.push_back(tag);
   endtask

   // monitor: compares the registered outputs a quarter period after each edge
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) check(tag_q.pop_front(), act, exp_q.pop_front());
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      model = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 check("R13 reset state", act, '0);
      drive("R13 idle hold",        0, 12'h000, 0, 0, 12'h000, 0, 32'h0000_00F0, 32'h1000, 3'b000);
      drive("R11 R6 general code",  1, 12'h180, 0, 0, 12'h000, 0, 32'h0000_8030, 32'h0C00_1000, 3'b000);
      drive("R13 taken one cycle",  0, 12'h000, 0, 0, 12'h000, 0, 32'h0000_0000, 32'h0000_0004, 3'b000);
      drive("R9 tlb read miss",     1, 12'h040, 0, 0, 12'h000, 0, 32'h0000_0010, 32'h0C00_2000, 3'b100);
      drive("R9 R7 tlb write slot", 1, 12'h060, 0, 0, 12'h000, 0, 32'h0000_0010, 32'h0C00_2010, 3'b101);
      drive("R10 trap",             1, 12'h160, 0, 0, 12'h000, 0, 32'h0000_0000, 32'h0C00_3000, 3'b000);
      drive("R10 R7 trap cond slot",1, 12'h160, 0, 0, 12'h000, 0, 32'h0000_0000, 32'h0C00_3100, 3'b110);
      drive("R8 code 020",          1, 12'h020, 0, 0, 12'h000, 0, 32'h0000_8020, 32'h0C00_4000, 3'b000);
      drive("R8 code 140",          1, 12'h140, 0, 0, 12'h000, 0, 32'h4000_8000, 32'h0C00_4100, 3'b000);
      drive("R2 R4 blocked to reset",1,12'h0A0, 0, 0, 12'h000, 0, 32'h1000_8000, 32'h0C00_5000, 3'b000);
      drive("R2 pass code",         1, 12'h1E0, 0, 0, 12'h000, 0, 32'h1000_0000, 32'h0C00_5100, 3'b000);
      drive("R12 irq accepted",     0, 12'h000, 1, 0, 12'h320, 0, 32'h0000_0050, 32'h0C00_6000, 3'b000);
      drive("R1 exc beats irq",     1, 12'h0E0, 1, 0, 12'h3C0, 0, 32'h0000_0050, 32'h0C00_6100, 3'b000);
      drive("R5 no vector",         0, 12'h000, 1, 1, 12'h400, 0, 32'h0000_0050, 32'h0C00_7000, 3'b000);
      drive("R3 irq blocked",       0, 12'h000, 1, 0, 12'h400, 0, 32'h1000_0000, 32'h0C00_7100, 3'b000);
      drive("R4 wake no vector",    0, 12'h000, 1, 1, 12'h400, 1, 32'h1000_0000, 32'h0C00_7200, 3'b000);
      drive("R4 R12 wake irq",      0, 12'h000, 1, 0, 12'h440, 1, 32'h1000_0000, 32'h0C00_7300, 3'b001);
      drive("R13 idle after irq",   0, 12'h000, 0, 0, 12'h000, 1, 32'h1000_0000, 32'h0C00_7400, 3'b011);
      drive("R13 back to back a",   1, 12'h100, 0, 0, 12'h000, 0, 32'h0000_0000, 32'h0C00_8000, 3'b000);
      drive("R13 back to back b",   1, 12'h0C0, 0, 0, 12'h000, 0, 32'h0000_0000, 32'h0C00_8004, 3'b000);
      drive("R13 final idle",       0, 12'h000, 0, 0, 12'h000, 0, 32'h0000_0000, 32'h0C00_9000, 3'b000);
      wait (exp_q.size() == 0);
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule